// File: doc/BRIEF.md
# Seconds Counter With Alarm

This block is a memory-mapped seconds timer. A slow reference clock reaches it as a one-cycle enable pulse (`slow_en`) inside the system clock domain. A programmable divider turns a set number of those pulses into one count step. A free-running 32-bit up-counter advances on each step and cannot be loaded. It can only be sent back to zero by a restart command. If the divider is programmed with the slow-clock frequency, the counter counts seconds. Software keeps its own base time elsewhere and adds it to the count.

A 32-bit compare register raises an alarm flag when the counter steps onto its value. Each count step also raises a step flag. Both flags are held in a status register and are cleared by reading it. One interrupt line combines each flag with its enable bit.

Access uses a simple synchronous bus. A write takes effect on the clock edge where `wr_en` is high. A read returns its data in `rd_data` one cycle after the edge where `rd_en` is high. The block has no state machine: every part of it is a register with a next-value rule, so no states or transitions are listed.

Top module: `sec_alarm_timer`

## Requirements
- R1: After reset the control register (offset 0x0) reads 0x00008000, the compare register (offset 0x4) reads 0xFFFFFFFF, the count register (offset 0x8) reads 0, the status register (offset 0xC) reads 0, and `irq` is low.
- R2: Control register fields are divisor in bits 15:0, alarm interrupt enable in bit 16, step interrupt enable in bit 17 and restart command in bit 18. Bits 17:0 read back as written, and bit 18 always reads 0.
- R3: The counter advances by exactly one after every N `slow_en` pulses, where N is the active divisor. It never changes in a cycle with `slow_en` low and no restart.
- R4: A control write with bit 18 set clears the counter and the divider phase, and makes the written divisor the active one. A control write with bit 18 clear does not change the active divisor.
- R5: Writes to the count register (offset 0x8) leave the counter unchanged.
- R6: A divisor of 0 acts as 65536 `slow_en` pulses per step.
- R7: Status bit 1 is set on every count step.
- R8: Status bit 0 is set on the step that makes the counter equal to the compare value, and not before that step.
- R9: A status read returns the flags held before the read and clears them.
- R10: A flag event that happens in the same cycle as a status read remains set after the read.
- R11: `irq` is high exactly while status bit 0 is set with control bit 16 set, or status bit 1 is set with control bit 17 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_en | input | 1 | One pulse per slow reference clock period |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the properties that hold locally. The counter stays still when there is no enable pulse and no restart. It never moves by more than one step. A restart always leaves it at zero. A status read with no event in the same cycle always leaves the flags clear. The alarm flag only rises when the count equals the compare value. The interrupt never rises while both enables are off. Only the directed scenarios can show the properties that depend on history. These are the exact step period for a given divisor, including the wide period for a zero divisor. They also include a divisor write that waits for a restart, the restart clearing a half-completed divider phase, the compare match firing on the correct step, and an event kept across a colliding status read.

// File: rtl/sat_pkg.sv
package sat_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 32;
    localparam int PRE_W   = 16;
    localparam int NFLAG   = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CMP    = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 4'hC;

    // enable bits sit 16 above the matching status bit
    localparam int EN_BASE     = 16;
    localparam int RESTART_BIT = 18;

    localparam int FLG_ALARM = 0;
    localparam int FLG_STEP  = 1;

    localparam logic [PRE_W-1:0] PRE_RESET = 16'h8000;
endpackage

// File: rtl/sat_divider.sv
module sat_divider #(
    parameter int PRE_W = 16,
    parameter logic [PRE_W-1:0] PRE_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_en,
    input  logic             restart,
    input  logic [PRE_W-1:0] ratio_in,
    output logic             step
);
    logic [PRE_W-1:0] ratio_q;
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] last_phase;

    // zero divisor means the full 2**PRE_W pulses
    assign last_phase = (ratio_q == '0) ? '1 : ratio_q - PRE_W'(1);
    assign step       = slow_en && !restart && (phase_q == last_phase);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q <= PRE_INIT;
            phase_q <= '0;
        end else if (restart) begin
            ratio_q <= ratio_in;
            phase_q <= '0;
        end else if (slow_en) begin
            phase_q <= (phase_q == last_phase) ? '0 : phase_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [CNT_W-1:0] cmp_value,
    output logic [CNT_W-1:0] count,
    output logic             alarm_hit
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_nxt;

    assign count_nxt = count_q + CNT_W'(1);
    assign alarm_hit = step && (count_nxt == cmp_value);
    assign count     = count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count_q <= '0;
        else if (restart) count_q <= '0;
        else if (step)    count_q <= count_nxt;
    end
endmodule

// File: rtl/sat_status.sv
module sat_status #(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_ev,
    input  logic             clear,
    input  logic [NFLAG-1:0] enable,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] masked;

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        // a set in the clearing cycle wins
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[gi] <= 1'b0;
            else        flag_q[gi] <= (clear ? 1'b0 : flag_q[gi]) | set_ev[gi];
        end
        assign masked[gi] = flag_q[gi] & enable[gi];
    end

    assign flags = flag_q;
    assign irq   = |masked;
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
    import sat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd_en,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [PRE_W-1:0] pre_q;
    logic [NFLAG-1:0] en_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] events;
    logic             wr_ctrl, wr_cmp, rd_status, restart;
    logic             step, alarm_hit;
    logic [DATA_W-1:0] rd_mux;

    assign wr_ctrl   = bus_wr_en && (bus_addr == OFS_CTRL);
    assign wr_cmp    = bus_wr_en && (bus_addr == OFS_CMP);
    assign rd_status = bus_rd_en && (bus_addr == OFS_STATUS);
    assign restart   = wr_ctrl && bus_wdata[RESTART_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= PRE_RESET;
            en_q  <= '0;
            cmp_q <= '1;
        end else begin
            if (wr_ctrl) begin
                pre_q <= bus_wdata[PRE_W-1:0];
                en_q  <= bus_wdata[EN_BASE +: NFLAG];
            end
            if (wr_cmp) cmp_q <= bus_wdata[CNT_W-1:0];
        end
    end

    sat_divider #(.PRE_W(PRE_W), .PRE_INIT(PRE_RESET)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_en  (slow_en),
        .restart  (restart),
        .ratio_in (bus_wdata[PRE_W-1:0]),
        .step     (step)
    );

    sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .step      (step),
        .cmp_value (cmp_q),
        .count     (cnt),
        .alarm_hit (alarm_hit)
    );

    always_comb begin
        events            = '0;
        events[FLG_ALARM] = alarm_hit;
        events[FLG_STEP]  = step;
    end

    sat_status #(.NFLAG(NFLAG)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (events),
        .clear  (rd_status),
        .enable (en_q),
        .flags  (flags),
        .irq    (irq)
    );

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_CTRL: begin
                rd_mux[PRE_W-1:0]         = pre_q;
                rd_mux[EN_BASE +: NFLAG]  = en_q;
            end
            OFS_CMP:    rd_mux = cmp_q;
            OFS_COUNT:  rd_mux = cnt;
            OFS_STATUS: rd_mux[NFLAG-1:0] = flags;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/sat_checker.sv
module sat_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        slow_en,
    input logic        restart,
    input logic        rd_status,
    input logic        step,
    input logic [31:0] cnt,
    input logic [31:0] cmp_q,
    input logic [1:0]  flags,
    input logic [1:0]  en_q,
    input logic        irq
);
    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slow_en && !restart) |=> $stable(cnt));

    // R3
    cnt_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (cnt == $past(cnt) || cnt == $past(cnt) + 32'd1));

    // R4
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == 32'd0));

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !step) |=> (flags == 2'b00));

    // R8
    alarm_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> (cnt == cmp_q));

    // R11
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_q != 2'b00));
endmodule

bind sec_alarm_timer sat_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_en   (slow_en),
    .restart   (restart),
    .rd_status (rd_status),
    .step      (step),
    .cnt       (cnt),
    .cmp_q     (cmp_q),
    .flags     (flags),
    .en_q      (en_q),
    .irq       (irq)
);

// File: tb/sim_sec_alarm_timer.sv
module sim_sec_alarm_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_alarm_timer u0 (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_addr(bus_addr),
        .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulses(input int n);
        @(negedge clk);
        slow_en = 1'b1;
        repeat (n) @(negedge clk);
        slow_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'd0, irq}, 32'd0);
        bus_read(4'h0, d); check("R1 ctrl", d, 32'h0000_8000);
        bus_read(4'h4, d); check("R1 cmp", d, 32'hFFFF_FFFF);
        bus_read(4'h8, d); check("R1 count", d, 32'd0);
        bus_read(4'hC, d); check("R1 status", d, 32'd0);
    endtask

    task automatic t_ctrl_readback();
        logic [31:0] d;
        bus_write(4'h0, 32'h0007_0007);
        bus_read(4'h0, d); check("R2 readback, restart reads 0", d, 32'h0003_0007);
        bus_write(4'h0, 32'h0004_0002);
        bus_read(4'h0, d); check("R2 enables off", d, 32'h0000_0002);
    endtask

    task automatic t_rate_restart();
        logic [31:0] d;
        bus_write(4'h0, 32'h0004_0002);
        pulses(3);
        bus_read(4'h8, d); check("R3 3 pulses div 2", d, 32'd1);
        repeat (5) @(negedge clk);
        bus_read(4'h8, d); check("R3 no slow_en", d, 32'd1);
        pulses(1);
        bus_read(4'h8, d); check("R3 4 pulses div 2", d, 32'd2);
        bus_write(4'h0, 32'h0000_0005);
        pulses(2);
        bus_read(4'h8, d); check("R4 divisor waits for restart", d, 32'd3);
        pulses(1);
        bus_write(4'h0, 32'h0004_0005);
        bus_read(4'h8, d); check("R4 restart clears", d, 32'd0);
        pulses(4);
        bus_read(4'h8, d); check("R4 phase cleared", d, 32'd0);
        pulses(1);
        bus_read(4'h8, d); check("R4 new divisor 5", d, 32'd1);
    endtask

    task automatic t_count_write();
        logic [31:0] d;
        bus_write(4'h8, 32'h0000_1234);
        bus_read(4'h8, d); check("R5 count write ignored", d, 32'd1);
    endtask

    task automatic t_alarm_irq();
        logic [31:0] d;
        bus_write(4'h0, 32'h0004_0002);
        bus_read(4'hC, d);
        bus_write(4'h4, 32'd3);
        bus_write(4'h0, 32'h0001_0002);
        pulses(4);
        check("R11 step flag not enabled", {31'd0, irq}, 32'd0);
        bus_read(4'hC, d); check("R7 R8 step flag only", d, 32'h2);
        pulses(2);
        check("R11 alarm irq", {31'd0, irq}, 32'd1);
        bus_read(4'hC, d); check("R8 alarm on match", d, 32'h3);
        check("R9 irq after clear", {31'd0, irq}, 32'd0);
        bus_read(4'hC, d); check("R9 status cleared", d, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        bus_write(4'h0, 32'h0006_0001);
        bus_read(4'hC, d);
        @(negedge clk);
        bus_addr = 4'hC; bus_rd_en = 1'b1; slow_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0; slow_en = 1'b0;
        check("R10 read returns old flags", bus_rdata, 32'h0);
        check("R11 step irq", {31'd0, irq}, 32'd1);
        bus_read(4'hC, d); check("R10 event kept", d, 32'h2);
    endtask

    task automatic t_zero_divisor();
        logic [31:0] d;
        bus_write(4'h0, 32'h0004_0000);
        pulses(65535);
        bus_read(4'h8, d); check("R6 65535 pulses", d, 32'd0);
        pulses(1);
        bus_read(4'h8, d); check("R6 65536 pulses", d, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_readback();
        t_rate_restart();
        t_count_write();
        t_alarm_irq();
        t_collision();
        t_zero_divisor();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule